// File: doc/BRIEF.md
# Two-Wire Serial Configuration-Memory Slave

This block sits on a two-wire serial bus, a clock line and an open-drain data line, and gives an external programmer write and read access to a small on-chip configuration array. The array is held in a synchronous RAM. Both bus inputs pass through a two-stage synchroniser before any edge is detected. The block drives the data line only through an open-drain pull-low enable.

A programmer opens a message with a start condition and then sends a device byte. A write continues with a two-byte memory address, most significant byte first, and then any number of data bytes. The slave pulls the line low to acknowledge each byte it accepts. A read begins at the current internal pointer and runs on as a sequential read for as long as the programmer acknowledges each byte. A stop that ends a write starts a self-timed busy window. During that window the bus is ignored and nothing is acknowledged, so the programmer learns that the write has finished by polling with device bytes until one is acknowledged.

After reset the array is swept to all zeros. The only way to give a location a known value is a serial write. The bus interface works only while the programming-mode enable is high.

Top module: `cfg_serial_slave`

## Requirements
- R1: A start condition (data falls while the clock is high) at any point, including partway through a byte, makes the next eight clocked bits a device byte.
- R2: A device byte is sent MSB first as {DEV_ID[6:0], rw}, where rw=1 means read. On a match the slave pulls data low during the ninth clock. On a mismatch the slave does not acknowledge and ignores the bus until the next start. The slave begins pulling low only while the clock is low.
- R3: A write message is a device byte with rw=0, then the address high byte, then the address low byte, then data bytes, and every byte is acknowledged. Address bits at and above ADDR_W are ignored. Each data byte is stored at the pointer, and the pointer then advances, so that it ends one past the last location written.
- R4: A stop after at least one data byte starts a busy window of WR_CYCLES clocks in which no byte is acknowledged. A write message that carries only address bytes starts no window.
- R5: A device byte with rw=1 returns the byte at the pointer, MSB first, and advances the pointer. Each acknowledge from the master fetches the next location, and the pointer wraps from the last location to 0.
- R6: A not-acknowledge from the master ends the read. The slave then leaves the data line released until the next start.
- R7: While prog_en is low the data line is released and no byte is acknowledged. Normal operation resumes with the next start after prog_en returns high.
- R8: After reset the data line is released and the array is zero-filled over 2**ADDR_W cycles, during which no byte is acknowledged. Every location then reads 0 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Programming-mode enable, synchronous to clk |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved level of the serial data line |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The hardest case to reach is the edge of the busy window. The slave must turn down a device byte sent straight after the stop and accept one sent once the window has run out. To get there, the bench polls at once after a multi-byte write, then polls again after a fixed delay that places the second device byte past WR_CYCLES. A second hard case is a start that arrives in the middle of a byte. The bench clocks out four address bits, issues a repeated start and expects the following read device byte to be acknowledged. The wrap from the last location to the first is reached with a high address byte whose ignored upper bits are all ones.

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int         ADDR_W    = 9,
  parameter logic [6:0] DEV_ID    = 7'h50,
  parameter int         WR_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_en,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK} st_t;
  typedef enum logic [1:0] {R_DEV, R_AHI, R_ALO, R_DATA} role_t;

  logic [2:0] scl_sy, sda_sy;
  logic scl_s, scl_q, sda_s, sda_q;
  logic start_c, stop_c, scl_rise, scl_fall;

  st_t              st;
  role_t            role;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, addr_hi, rdata;
  logic [ADDR_W-1:0] ptr, clr_cnt;
  logic             rd_mode, mack, wrote, clearing;
  logic [BW-1:0]    busy_cnt;
  logic             busy, run, idle, wr_fire;
  logic [7:0]       mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  assign scl_s    = scl_sy[1];
  assign scl_q    = scl_sy[2];
  assign sda_s    = sda_sy[1];
  assign sda_q    = sda_sy[2];
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  assign busy    = (busy_cnt != '0);
  assign run     = prog_en & ~busy & ~clearing;
  assign idle    = (st == S_IDLE);
  assign wr_fire = run & ~start_c & ~stop_c & (st == S_RX) & scl_fall
                 & (bitcnt == 4'd8) & (role == R_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_cnt  <= '0;
    end else if (clearing) begin
      clr_cnt <= clr_cnt + 1'b1;
      if (clr_cnt == ADDR_W'(DEPTH - 1)) clearing <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     busy_cnt <= '0;
    else if (run && stop_c && wrote) busy_cnt <= BW'(WR_CYCLES);
    else if (busy)                   busy_cnt <= busy_cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (clearing)     mem[clr_cnt] <= 8'h00;
    else if (wr_fire) mem[ptr]     <= shreg;
    rdata <= mem[ptr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      role    <= R_DEV;
      bitcnt  <= '0;
      shreg   <= '0;
      addr_hi <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      wrote   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (!run) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      wrote  <= 1'b0;
    end else if (start_c) begin
      st     <= S_RX;
      role   <= R_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      wrote  <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            case (role)
              R_DEV:
                if (shreg[7:1] == DEV_ID) begin
                  st      <= S_RX_ACK;
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                  role    <= R_AHI;
                end else begin
                  st <= S_IDLE;
                end
              R_AHI: begin
                addr_hi <= shreg;
                role    <= R_ALO;
                st      <= S_RX_ACK;
                sda_oe  <= 1'b1;
              end
              R_ALO: begin
                ptr    <= ADDR_W'({addr_hi, shreg});
                role   <= R_DATA;
                st     <= S_RX_ACK;
                sda_oe <= 1'b1;
              end
              R_DATA: begin
                ptr    <= ptr + 1'b1;
                wrote  <= 1'b1;
                st     <= S_RX_ACK;
                sda_oe <= 1'b1;
              end
            endcase
          end
        end
        S_RX_ACK:
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              st     <= S_TX;
              shreg  <= rdata;
              sda_oe <= ~rdata[7];
              ptr    <= ptr + 1'b1;
            end else begin
              st     <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              st     <= S_TX_ACK;
              sda_oe <= 1'b0;
              bitcnt <= '0;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        S_TX_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              st     <= S_TX;
              shreg  <= rdata;
              sda_oe <= ~rdata[7];
              ptr    <= ptr + 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end

endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_en,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              busy,
  input logic              clearing,
  input logic              idle,
  input logic              wr_fire,
  input logic [ADDR_W-1:0] ptr
);

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> !sda_oe);

  p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !sda_oe);

  p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |=> !sda_oe);

  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  p_drive_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ptr == $past(ptr) + 1'b1);

endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sda_oe(sda_oe),
  .scl_s(scl_s), .busy(busy), .clearing(clearing), .idle(idle),
  .wr_fire(wr_fire), .ptr(ptr)
);

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;
  localparam int ADDR_W = 9;
  localparam int WR     = 1500;
  localparam int Q      = 10;

  logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b1, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  cfg_serial_slave #(.ADDR_W(ADDR_W), .DEV_ID(7'h50), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe));

  typedef struct {logic [7:0] v; string tag;} item_t;
  item_t      exp_q[$];
  logic [7:0] got_q[$];
  event       got_ev;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; hold(Q); scl = 1; hold(Q); m_sda = 0; hold(Q); scl = 0; hold(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; hold(Q); scl = 1; hold(Q); m_sda = 1; hold(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hold(Q); scl = 1; hold(2 * Q); scl = 0; hold(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit want, input string tag);
    bit acked;
    send_bits(b, 8);
    m_sda = 1; hold(Q); scl = 1; hold(Q);
    acked = (sda_line == 1'b0);
    hold(Q); scl = 0; hold(Q);
    check(acked == want, tag, acked, want);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    item_t it;
    it.v = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic recv_byte(input bit give_ack);
    logic [7:0] v;
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl = 1; hold(Q); v[i] = sda_line; hold(Q); scl = 0; hold(Q);
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    hold(Q); scl = 1; hold(2 * Q); scl = 0; hold(Q);
    m_sda = 1;
    got_q.push_back(v);
    ->got_ev;
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    bus_start;
    send_byte(8'hA0, 1, tag);
    send_byte(hi, 1, tag);
    send_byte(lo, 1, tag);
    bus_stop;
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() > 0) begin
        logic [7:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) check(0, "scoreboard unexpected byte", g, 0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          check(g == e.v, e.tag, g, e.v);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      finish_up;
    end
  end

  initial begin
    hold(5); rst_n = 1; hold(3);
    check(sda_oe == 1'b0, "R8 line released after reset", sda_oe, 0);

    // R8: bus ignored while the array is swept
    bus_start;
    send_byte(8'hA0, 0, "R8 no ack during clear sweep");
    bus_stop;
    hold(600);

    // R3/R4: address-only write, no busy window; R8 zero contents
    set_ptr(8'h00, 8'h10, "R3 address byte ack");
    bus_start;
    send_byte(8'hA1, 1, "R4 no busy after address-only write");
    expect_byte(8'h00, "R8 cleared location 0x10");
    recv_byte(1);
    expect_byte(8'h00, "R8 cleared location 0x11");
    recv_byte(0);
    bus_stop;

    // R3: four data bytes
    bus_start;
    send_byte(8'hA0, 1, "R2 device write ack");
    send_byte(8'h00, 1, "R3 addr hi ack");
    send_byte(8'h10, 1, "R3 addr lo ack");
    send_byte(8'h11, 1, "R3 data ack");
    send_byte(8'h22, 1, "R3 data ack");
    send_byte(8'h33, 1, "R3 data ack");
    send_byte(8'h44, 1, "R3 data ack");
    bus_stop;

    // R4: polling during and after the busy window
    bus_start;
    send_byte(8'hA0, 0, "R4 no ack while busy");
    bus_stop;
    hold(1200);
    bus_start;
    send_byte(8'hA0, 1, "R4 ack after busy window");
    bus_stop;

    // R3: pointer ends one past last written
    bus_start;
    send_byte(8'hA0, 1, "R3 device ack");
    send_byte(8'h00, 1, "R3 addr hi ack");
    send_byte(8'h10, 1, "R3 addr lo ack");
    send_byte(8'hAA, 1, "R3 data ack");
    send_byte(8'hBB, 1, "R3 data ack");
    bus_stop;
    hold(WR + 100);
    bus_start;
    send_byte(8'hA1, 1, "R5 device read ack");
    expect_byte(8'h33, "R3 pointer one past last write");
    recv_byte(1);
    expect_byte(8'h44, "R5 sequential next byte");
    recv_byte(0);
    expect_byte(8'hFF, "R6 line released after master nack");
    recv_byte(0);
    bus_stop;

    // R5: sequential read from a set pointer
    set_ptr(8'h00, 8'h10, "R5 set pointer ack");
    bus_start;
    send_byte(8'hA1, 1, "R5 device read ack");
    expect_byte(8'hAA, "R5 seq byte 0");  recv_byte(1);
    expect_byte(8'hBB, "R5 seq byte 1");  recv_byte(1);
    expect_byte(8'h33, "R5 seq byte 2");  recv_byte(1);
    expect_byte(8'h44, "R5 seq byte 3");  recv_byte(0);
    bus_stop;

    // R3/R5: wrap at the top, upper address bits ignored
    bus_start;
    send_byte(8'hA0, 1, "R3 device ack");
    send_byte(8'h01, 1, "R3 addr hi ack");
    send_byte(8'hFF, 1, "R3 addr lo ack");
    send_byte(8'hC1, 1, "R3 data ack last location");
    send_byte(8'hC2, 1, "R3 data ack wrapped location");
    bus_stop;
    hold(WR + 100);
    set_ptr(8'hFF, 8'hFF, "R3 high bits ignored ack");
    bus_start;
    send_byte(8'hA1, 1, "R5 device read ack");
    expect_byte(8'hC1, "R3 upper address bits ignored"); recv_byte(1);
    expect_byte(8'hC2, "R5 wrap to location 0");         recv_byte(0);
    bus_stop;

    // R1: start in the middle of a byte
    bus_start;
    send_byte(8'hA0, 1, "R1 device ack before abort");
    send_bits(8'h5A, 4);
    bus_start;
    send_byte(8'hA1, 1, "R1 device byte after mid-byte start");
    expect_byte(8'h00, "R1 read after restart");
    recv_byte(0);
    bus_stop;

    // R2: address mismatch
    bus_start;
    send_byte(8'hB0, 0, "R2 mismatched device no ack");
    send_byte(8'h00, 0, "R2 bytes after mismatch ignored");
    bus_stop;

    // R7: programming enable
    prog_en = 0;
    bus_start;
    send_byte(8'hA0, 0, "R7 no ack with prog_en low");
    bus_stop;
    prog_en = 1;
    hold(5);
    bus_start;
    send_byte(8'hA0, 1, "R7 ack after prog_en back");
    bus_stop;

    hold(50);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    done = 1;
    finish_up;
  end
endmodule